// File: doc/BRIEF.md
# Half-Cycle Updated RMS Engine

This block produces root-mean-square values for seven measurement channels: the three phase voltages, the three phase currents and the neutral current. Each result covers one full line cycle. The cycle is split into two halves, and a new set of results appears each time a half closes, so the output refreshes twice per line cycle. Samples for all channels arrive together on one valid strobe. For each channel a select bit picks either the pre-filter sample or the post-integrator sample.

The length of a half is derived from a period count, in samples per line cycle. By default this count comes from a measured line-period input. A configuration bit substitutes a user-programmed period instead. Squared samples build up in a per-channel half-cycle sum. When a half closes, the two latest halves form the window. A single sequential divide and square-root engine then walks the channels one after another. It adds a signed per-channel offset, limits the value to the output range, and publishes all seven results in the same cycle as a one-cycle ready pulse.

Channel k occupies bits [k*W +: W] of every flat bus. Channels 0 to 2 are the phase voltages, 3 to 5 the phase currents, and 6 the neutral current.

Top module: `halfcyc_rms_engine`

## Requirements
- R1: While reset is asserted and until the first ready pulse, every result is zero and rms_rdy is low.
- R2: Before offset, each channel's result equals floor(sqrt(floor(S/D))). S is the sum of squared selected samples over the two most recent closed halves, and D is the total number of samples in those two halves.
- R3: rms_rdy is a single-cycle pulse after each window computation. All results change only in the cycle in which rms_rdy is high, and they hold their values between pulses.
- R4: The half length is floor(P/2), with a minimum of 1, where P is the selected period. P is read while reset is asserted and on the sample that closes a half. A change of P in the middle of a half does not alter that half, and no ready pulse arrives before the half closes.
- R5: With use_user_period high, P is user_period. With it low, P is meas_period.
- R6: With src_post high, each channel uses smp_post. With it low, each channel uses smp_pre. The unselected input has no effect on any result.
- R7: rms_offset holds a signed two's-complement value per channel, added to the root. A negative total gives 0, and a total above 2^OW-1 gives 2^OW-1 (67,108,863 by default).
- R8: A full-scale sample stream of constant magnitude 52,702,092, of either sign, with zero offset gives a result of 52,702,092.
- R9: The first window after reset covers only the first half, so D is that half's length.
- R10: If another half closes before the current computation is published, that computation is dropped and no ready pulse is given for it. The next pulse carries the results for the newest window.
- R11: Channel k is carried in bits [k*W +: W] of smp_pre, smp_post, rms_offset and rms_val, with W the respective field width. Channels are computed independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | One-cycle strobe: one new sample for every channel |
| src_post | input | 1 | 1 selects post-integrator samples, 0 pre-filter samples |
| smp_pre | input | NCH*SW | Signed pre-filter samples, one field per channel |
| smp_post | input | NCH*SW | Signed post-integrator samples, one field per channel |
| meas_period | input | PW | Measured line period in samples |
| user_period | input | PW | User-programmed line period in samples |
| use_user_period | input | 1 | 1 selects user_period over meas_period |
| rms_offset | input | NCH*OFW | Signed offset per channel, added after the root |
| rms_val | output | NCH*OW | RMS results, one field per channel |
| rms_rdy | output | 1 | One-cycle pulse when all results update together |

## Verification
The hardest situation to reach is a half closing while the shared root engine is still working through the channels. This needs half lengths far shorter than one full computation, which takes several hundred cycles. The stimulus reaches it by switching the period to 2, so each sample closes a half, and pushing samples every other cycle. It then confirms that no ready pulse appears during the burst and that the result which finally arrives matches the last two one-sample halves. Period changes in the middle of a half are driven the same way, with the new period applied partway through a half while the bench model keeps the old length until the boundary.

// File: rtl/rms_pkg.sv
package rms_pkg;

  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_LOAD,
    ENG_DIV,
    ENG_SQRT,
    ENG_FIN
  } eng_state_t;

  // Sum of squares over a full window, rounded up to an even width for the root
  function automatic int acc_width(input int sw, input int pw);
    int w;
    w = 2 * sw - 1 + pw;
    return w + (w % 2);
  endfunction

endpackage

// File: rtl/rms_window_ctrl.sv
module rms_window_ctrl #(
  parameter int PW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          smp_vld,
  input  logic [PW-1:0] meas_period,
  input  logic [PW-1:0] user_period,
  input  logic          use_user_period,
  output logic          half_last,
  output logic          win_done,
  output logic [PW-1:0] win_len
);

  logic [PW-1:0] sel_p;
  logic [PW-1:0] new_h;
  logic [PW-1:0] h_cur;
  logic [PW-1:0] h_prev;
  logic [PW-1:0] cnt;

  always_comb begin
    sel_p = use_user_period ? user_period : meas_period;
    new_h = sel_p >> 1;
    if (new_h == '0) new_h = PW'(1);
  end

  assign half_last = smp_vld && (cnt == h_cur - PW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      h_cur    <= new_h;
      h_prev   <= '0;
      win_done <= 1'b0;
      win_len  <= PW'(1);
    end else begin
      win_done <= half_last;
      if (smp_vld) begin
        if (half_last) begin
          cnt     <= '0;
          win_len <= h_prev + h_cur;
          h_prev  <= h_cur;
          h_cur   <= new_h;
        end else begin
          cnt <= cnt + PW'(1);
        end
      end
    end
  end

  AST_CNT_IN_HALF: assert property (@(posedge clk) disable iff (rst)
    cnt < h_cur); // R4

  AST_HALF_HOLD: assert property (@(posedge clk) disable iff (rst)
    !half_last |=> $stable(h_cur)); // R4

endmodule

// File: rtl/rms_lane.sv
module rms_lane #(
  parameter int SW   = 27,
  parameter int ACCW = 64
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 smp_vld,
  input  logic                 half_last,
  input  logic                 src_post,
  input  logic signed [SW-1:0] s_pre,
  input  logic signed [SW-1:0] s_post,
  output logic [ACCW-1:0]      full_sum
);

  localparam int PRW = 2 * SW;

  logic signed [SW-1:0]  s_sel;
  logic signed [PRW-1:0] prod;
  logic [ACCW-1:0]       sq;
  logic [ACCW-1:0]       acc;
  logic [ACCW-1:0]       prev_half;
  logic [ACCW-1:0]       half_sum;

  always_comb begin
    s_sel    = src_post ? s_post : s_pre;
    prod     = s_sel * s_sel;
    sq       = {{(ACCW-PRW){1'b0}}, prod};
    half_sum = acc + sq;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc       <= '0;
      prev_half <= '0;
      full_sum  <= '0;
    end else if (smp_vld) begin
      if (half_last) begin
        full_sum  <= prev_half + half_sum;
        prev_half <= half_sum;
        acc       <= '0;
      end else begin
        acc <= half_sum;
      end
    end
  end

  AST_ACC_GROWS: assert property (@(posedge clk) disable iff (rst)
    (smp_vld && !half_last) |=> acc >= $past(acc)); // R2

endmodule

// File: rtl/rms_root_engine.sv
module rms_root_engine import rms_pkg::*; #(
  parameter int NCH  = 7,
  parameter int PW   = 10,
  parameter int ACCW = 64,
  parameter int OFW  = 24,
  parameter int OW   = 26
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [PW-1:0]       win_len,
  input  logic [NCH*ACCW-1:0] full_flat,
  input  logic [NCH*OFW-1:0]  off_flat,
  output logic [NCH*OW-1:0]   rms_flat,
  output logic                rms_rdy
);

  localparam int RW  = ACCW / 2;
  localparam int TW  = RW + 2;
  localparam int CW  = $clog2(ACCW) + 1;
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic signed [TW-1:0] MAXV = {{(TW-OW){1'b0}}, {OW{1'b1}}};

  eng_state_t     st;
  logic [CHW-1:0] ch;
  logic [CW-1:0]  step;
  logic [ACCW-1:0] num;
  logic [ACCW-1:0] res;
  logic [ACCW-1:0] bitv;
  logic [ACCW-1:0] q_hold;
  logic [PW-1:0]   rem;

  logic [ACCW-1:0] fs_arr [NCH];
  logic [OFW-1:0]  off_arr [NCH];
  logic [OW-1:0]   stage [NCH];
  logic [OW-1:0]   out_q [NCH];

  for (genvar k = 0; k < NCH; k++) begin : g_unpack
    assign fs_arr[k]               = full_flat[k*ACCW +: ACCW];
    assign off_arr[k]              = off_flat[k*OFW +: OFW];
    assign rms_flat[k*OW +: OW]    = out_q[k];
  end

  // Restoring division step
  logic [PW:0]     tmp;
  logic            qbit;
  logic [ACCW-1:0] nq;
  logic [PW-1:0]   nrem;
  // Bit-serial root step
  logic [ACCW-1:0] trial;
  // Offset and limit
  logic [RW-1:0]          root;
  logic signed [TW-1:0]   tot;
  logic [OW-1:0]          val;
  logic [OFW-1:0]         off_cur;

  always_comb begin
    tmp   = {rem, num[ACCW-1]};
    qbit  = tmp >= {1'b0, win_len};
    nq    = {num[ACCW-2:0], qbit};
    nrem  = qbit ? PW'(tmp - {1'b0, win_len}) : tmp[PW-1:0];
    trial = res + bitv;
    root  = res[RW-1:0];
    off_cur = off_arr[ch];
    tot   = $signed({2'b00, root}) + $signed({{(TW-OFW){off_cur[OFW-1]}}, off_cur});
    if (tot < 0)         val = '0;
    else if (tot > MAXV) val = {OW{1'b1}};
    else                 val = tot[OW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ENG_IDLE;
      ch      <= '0;
      step    <= '0;
      num     <= '0;
      res     <= '0;
      bitv    <= '0;
      q_hold  <= '0;
      rem     <= '0;
      rms_rdy <= 1'b0;
      for (int k = 0; k < NCH; k++) begin
        stage[k] <= '0;
        out_q[k] <= '0;
      end
    end else begin
      rms_rdy <= 1'b0;
      if (start) begin
        st <= ENG_LOAD;
        ch <= '0;
      end else begin
        case (st)
          ENG_LOAD: begin
            num  <= fs_arr[ch];
            rem  <= '0;
            step <= '0;
            st   <= ENG_DIV;
          end
          ENG_DIV: begin
            num  <= nq;
            rem  <= nrem;
            step <= step + CW'(1);
            if (step == CW'(ACCW-1)) begin
              st     <= ENG_SQRT;
              step   <= '0;
              q_hold <= nq;
              res    <= '0;
              bitv   <= ACCW'(1) << (ACCW-2);
            end
          end
          ENG_SQRT: begin
            if (num >= trial) begin
              num <= num - trial;
              res <= (res >> 1) + bitv;
            end else begin
              res <= res >> 1;
            end
            bitv <= bitv >> 2;
            step <= step + CW'(1);
            if (step == CW'(RW-1)) st <= ENG_FIN;
          end
          ENG_FIN: begin
            stage[ch] <= val;
            if (ch == CHW'(NCH-1)) begin
              for (int k = 0; k < NCH-1; k++) out_q[k] <= stage[k];
              out_q[NCH-1] <= val;
              rms_rdy      <= 1'b1;
              st           <= ENG_IDLE;
            end else begin
              ch <= ch + CHW'(1);
              st <= ENG_LOAD;
            end
          end
          default: st <= ENG_IDLE;
        endcase
      end
    end
  end

  // Root check: root^2 <= quotient < (root+1)^2
  logic [ACCW:0] r_ext, sq_lo, sq_hi, q_ext;
  always_comb begin
    r_ext = {{(ACCW-RW+1){1'b0}}, root};
    sq_lo = r_ext * r_ext;
    sq_hi = (r_ext + (ACCW+1)'(1)) * (r_ext + (ACCW+1)'(1));
    q_ext = {1'b0, q_hold};
  end

  AST_ROOT_EXACT: assert property (@(posedge clk) disable iff (rst)
    (st == ENG_FIN) |-> (sq_lo <= q_ext && sq_hi > q_ext)); // R2

  AST_RDY_PULSE: assert property (@(posedge clk) disable iff (rst)
    rms_rdy |=> !rms_rdy); // R3

  AST_OUT_WITH_RDY: assert property (@(posedge clk) disable iff (rst)
    !$stable(rms_flat) |-> rms_rdy); // R3

endmodule

// File: rtl/halfcyc_rms_engine.sv
module halfcyc_rms_engine import rms_pkg::*; #(
  parameter int NCH = 7,
  parameter int SW  = 27,
  parameter int PW  = 10,
  parameter int OFW = 24,
  parameter int OW  = 26
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               smp_vld,
  input  logic               src_post,
  input  logic [NCH*SW-1:0]  smp_pre,
  input  logic [NCH*SW-1:0]  smp_post,
  input  logic [PW-1:0]      meas_period,
  input  logic [PW-1:0]      user_period,
  input  logic               use_user_period,
  input  logic [NCH*OFW-1:0] rms_offset,
  output logic [NCH*OW-1:0]  rms_val,
  output logic               rms_rdy
);

  localparam int ACCW = acc_width(SW, PW);

  logic                half_last;
  logic                win_done;
  logic [PW-1:0]       win_len;
  logic [NCH*ACCW-1:0] full_flat;

  rms_window_ctrl #(.PW(PW)) u_ctrl (
    .clk             (clk),
    .rst             (rst),
    .smp_vld         (smp_vld),
    .meas_period     (meas_period),
    .user_period     (user_period),
    .use_user_period (use_user_period),
    .half_last       (half_last),
    .win_done        (win_done),
    .win_len         (win_len)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_lane
    rms_lane #(.SW(SW), .ACCW(ACCW)) u_lane (
      .clk       (clk),
      .rst       (rst),
      .smp_vld   (smp_vld),
      .half_last (half_last),
      .src_post  (src_post),
      .s_pre     (smp_pre[k*SW +: SW]),
      .s_post    (smp_post[k*SW +: SW]),
      .full_sum  (full_flat[k*ACCW +: ACCW])
    );
  end

  rms_root_engine #(
    .NCH(NCH), .PW(PW), .ACCW(ACCW), .OFW(OFW), .OW(OW)
  ) u_eng (
    .clk       (clk),
    .rst       (rst),
    .start     (win_done),
    .win_len   (win_len),
    .full_flat (full_flat),
    .off_flat  (rms_offset),
    .rms_flat  (rms_val),
    .rms_rdy   (rms_rdy)
  );

endmodule

// File: tb/sim_halfcyc_rms_engine.sv
module sim_halfcyc_rms_engine;

  localparam int NCH = 7, SW = 27, PW = 10, OFW = 24, OW = 26;
  localparam longint FS = 52702092;
  localparam longint MAXO = (64'sd1 <<< OW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic smp_vld = 1'b0, src_post = 1'b0, use_user_period = 1'b0;
  logic [NCH*SW-1:0]  smp_pre = '0, smp_post = '0;
  logic [PW-1:0]      meas_period = '0, user_period = '0;
  logic [NCH*OFW-1:0] rms_offset = '0;
  logic [NCH*OW-1:0]  rms_val;
  logic               rms_rdy;

  always #2 clk = ~clk;

  halfcyc_rms_engine #(.NCH(NCH), .SW(SW), .PW(PW), .OFW(OFW), .OW(OW)) u0 (
    .clk(clk), .rst(rst), .smp_vld(smp_vld), .src_post(src_post),
    .smp_pre(smp_pre), .smp_post(smp_post), .meas_period(meas_period),
    .user_period(user_period), .use_user_period(use_user_period),
    .rms_offset(rms_offset), .rms_val(rms_val), .rms_rdy(rms_rdy));

  int n_chk = 0, n_fail = 0, rdy_cnt = 0;
  int m_cnt, m_h, m_hprev;
  longint unsigned m_acc [NCH];
  longint unsigned m_prev [NCH];
  longint exp_v [NCH];
  longint offs [NCH];
  logic signed [SW-1:0] pre_s [NCH];
  logic signed [SW-1:0] post_s [NCH];
  bit fs_sign = 1'b0;

  always @(negedge clk) if (!rst && rms_rdy) rdy_cnt++;

  function automatic int sel_h();
    int p = use_user_period ? int'(user_period) : int'(meas_period);
    return (p / 2 == 0) ? 1 : p / 2;
  endfunction

  function automatic longint unsigned isqrt_bs(input longint unsigned v);
    longint unsigned lo = 0, hi = 64'hFFFF_FFFF, mid;
    while (lo < hi) begin
      mid = (lo + hi + 1) >> 1;
      if (mid * mid <= v) lo = mid; else hi = mid - 1;
    end
    return lo;
  endfunction

  function automatic longint expect_val(input longint unsigned s, input int d, input longint off);
    longint t = longint'(isqrt_bs(s / longint'(d))) + off;
    if (t < 0) return 0;
    if (t > MAXO) return MAXO;
    return t;
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint expv);
    n_chk++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic gen(input int mode);
    for (int c = 0; c < NCH; c++) begin
      case (mode)
        0: begin pre_s[c] = SW'($urandom); post_s[c] = SW'($urandom); end
        1: begin
             pre_s[c]  = fs_sign ? -SW'(FS) : SW'(FS);
             post_s[c] = pre_s[c];
           end
        2: begin
             pre_s[c]  = SW'(int'($urandom_range(0, 2000)) - 1000);
             post_s[c] = SW'(int'($urandom_range(0, 2000)) - 1000);
           end
        default: begin pre_s[c] = {1'b1, {(SW-1){1'b0}}}; post_s[c] = pre_s[c]; end
      endcase
    end
    fs_sign = ~fs_sign;
  endtask

  task automatic set_offsets();
    for (int c = 0; c < NCH; c++) rms_offset[c*OFW +: OFW] = OFW'(offs[c]);
  endtask

  task automatic push();
    longint sv;
    @(negedge clk);
    for (int c = 0; c < NCH; c++) begin
      smp_pre[c*SW +: SW]  = pre_s[c];
      smp_post[c*SW +: SW] = post_s[c];
      sv = src_post ? longint'(post_s[c]) : longint'(pre_s[c]);
      m_acc[c] += longint'(sv * sv);
    end
    smp_vld = 1'b1;
    m_cnt++;
    if (m_cnt == m_h) begin
      for (int c = 0; c < NCH; c++) begin
        exp_v[c]  = expect_val(m_prev[c] + m_acc[c], m_hprev + m_h, offs[c]);
        m_prev[c] = m_acc[c];
        m_acc[c]  = 0;
      end
      m_hprev = m_h;
      m_h     = sel_h();
      m_cnt   = 0;
    end
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  task automatic wait_check(input int base, input string req);
    int t = 0;
    while (rdy_cnt == base && t < 4000) begin @(negedge clk); t++; end
    chk(req, "ready pulse seen", (rdy_cnt != base) ? 1 : 0, 1);
    for (int c = 0; c < NCH; c++)
      chk({req, " R11"}, $sformatf("ch%0d", c), longint'(rms_val[c*OW +: OW]), exp_v[c]);
  endtask

  // Run one complete half; optionally change meas_period partway, optionally probe for early ready
  task automatic run_half(input int mode, input int chg_at, input int newp, input bit probe, input string req);
    int n = m_h;
    int base = rdy_cnt;
    for (int i = 0; i < n; i++) begin
      if (i == chg_at) meas_period = PW'(newp);
      gen(mode);
      if (probe && i == n - 1) begin
        repeat (800) @(negedge clk);
        chk("R4", "no ready before half closes", rdy_cnt, base);
      end
      push();
    end
    wait_check(base, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'd4242));
    meas_period = PW'(16);
    user_period = PW'(100);
    for (int c = 0; c < NCH; c++) begin
      offs[c] = 0; m_acc[c] = 0; m_prev[c] = 0; exp_v[c] = 0;
      pre_s[c] = '0; post_s[c] = '0;
    end
    set_offsets();
    repeat (5) @(negedge clk);
    m_h = sel_h(); m_hprev = 0; m_cnt = 0;
    chk("R1", "results in reset", longint'(rms_val != '0), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "results after reset", longint'(rms_val != '0), 0);
    chk("R1", "ready after reset", longint'(rms_rdy), 0);

    // Full scale, first window is one half only
    run_half(1, -1, 0, 1'b0, "R8 R9");
    chk("R8", "full scale ch0", longint'(rms_val[0 +: OW]), FS);
    run_half(1, -1, 0, 1'b0, "R8 R2");
    chk("R8", "full scale ch6", longint'(rms_val[6*OW +: OW]), FS);

    // Hold between pulses
    base = rdy_cnt;
    repeat (100) @(negedge clk);
    chk("R3", "no extra ready", rdy_cnt, base);
    for (int c = 0; c < NCH; c++)
      chk("R3", $sformatf("hold ch%0d", c), longint'(rms_val[c*OW +: OW]), exp_v[c]);

    // Random windows, source select, mid-half period changes
    for (int w = 0; w < 8; w++) begin
      src_post = 1'($urandom);
      for (int c = 0; c < NCH; c++) offs[c] = longint'(int'($urandom_range(0, 200000)) - 100000);
      set_offsets();
      run_half(0, 2, int'($urandom_range(8, 40)), w == 3, src_post ? "R6 R2 post" : "R6 R2 pre");
    end

    // User period override
    use_user_period = 1'b1; user_period = PW'(10); meas_period = PW'(40);
    run_half(0, -1, 0, 1'b0, "R5");
    run_half(0, -1, 0, 1'b1, "R5 R4");
    user_period = PW'(11);
    run_half(2, -1, 0, 1'b0, "R4 odd");
    run_half(2, -1, 0, 1'b0, "R4 odd");
    user_period = PW'(1);
    run_half(0, -1, 0, 1'b0, "R4 min");
    run_half(0, -1, 0, 1'b0, "R4 min");
    user_period = PW'(12);
    run_half(0, -1, 0, 1'b0, "R5");

    // Offset clamp at zero and saturation
    for (int c = 0; c < NCH; c++) offs[c] = -(64'sd1 <<< (OFW-1));
    set_offsets();
    run_half(2, -1, 0, 1'b0, "R7 floor");
    run_half(2, -1, 0, 1'b0, "R7 floor");
    chk("R7", "floor ch3", longint'(rms_val[3*OW +: OW]), 0);
    for (int c = 0; c < NCH; c++) offs[c] = (c == 0) ? 0 : 1000;
    set_offsets();
    run_half(3, -1, 0, 1'b0, "R7 sat");
    run_half(3, -1, 0, 1'b0, "R7 sat");
    chk("R7", "saturated ch0", longint'(rms_val[0 +: OW]), MAXO);

    // Overlapping windows: each sample closes a half
    for (int c = 0; c < NCH; c++) offs[c] = 0;
    set_offsets();
    use_user_period = 1'b0; meas_period = PW'(2);
    base = rdy_cnt;
    for (int i = 0; i < 6 + 12; i++) begin
      gen(0);
      push();
      if (m_hprev == 1 && i > 6) break;
    end
    for (int i = 0; i < 6; i++) begin gen(0); push(); end
    chk("R10", "no ready during overlap", rdy_cnt, base);
    wait_check(base, "R10");
    meas_period = PW'(16);
    run_half(0, -1, 0, 1'b0, "R10 R4");
    run_half(0, -1, 0, 1'b0, "R2");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule